// File: doc/BRIEF.md
# Interrupt Steering and Vector Register File

This block collects a set of level-sensitive interrupt request lines and steers each one to one of two processor interrupt outputs: a normal interrupt and a fast interrupt. Software chooses each line's class with a per-bit class mask. It turns each line on or off through set-only and clear-only enable ports. It can read back, separately for each class, which enabled lines are asserting.

Each source also owns a writable vector slot that holds the address of its service routine. A current-vector register returns the slot of the lowest-numbered normal-class source that is pending. The interrupt handler reads it to jump straight to the right routine. All access is through a simple synchronous register bus. The bus takes one transfer per cycle, has a write strobe, and returns read data combinationally for the presented byte address.

Top module: `intc_vec_regs`

## Requirements
- R1: After reset the class mask, the enable mask and every vector slot are 0. Both status views read 0 and both interrupt outputs are low.
- R2: Offset 0x008 reads the request lines as sampled at the previous clock edge, with no enable or class masking.
- R3: A write to offset 0x014 sets each enable bit whose write-data bit is 1 and leaves the rest unchanged. The enable mask reads back at offset 0x010.
- R4: A write to offset 0x018 clears each enable bit whose write-data bit is 1 and leaves the rest unchanged.
- R5: Offset 0x00C is the read/write class mask. Bit n at 0 places source n in the normal class, and bit n at 1 places it in the fast class.
- R6: Offset 0x000 reads, in bit n, sampled line n AND enable n AND class n equal to 0.
- R7: Offset 0x004 reads, in bit n, sampled line n AND enable n AND class n equal to 1. Several bits may be set together.
- R8: The normal interrupt output is the OR of the normal-class status bits, and the fast interrupt output is the OR of the fast-class status bits. Each follows a request line change after one clock edge.
- R9: The vector slot for source n is a 32-bit read/write register at offset 0x100 + 4·n.
- R10: Offset 0xF00 reads the vector slot of the lowest-numbered source set in the normal-class status, or 0 when that status is 0.
- R11: Writes to the read-only offsets 0x000, 0x004, 0x008, 0x010 and 0xF00 change no state. Reads of 0x014, 0x018, unaligned addresses and unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| busAddr | input | ADDR_W (12) | Byte address of the register access |
| busWe | input | 1 | Write strobe for the current cycle |
| busWdata | input | DATA_W (32) | Write data |
| busRdata | output | DATA_W (32) | Read data for busAddr, combinational |
| srcReq | input | NUM_SRC (32) | Level-sensitive interrupt request lines |
| irqOut | output | 1 | Normal interrupt request to the processor |
| fiqOut | output | 1 | Fast interrupt request to the processor |

## Verification
The bench builds the block with its defaults: 32 sources, 32-bit data and vectors, and a 12-bit address. This places every source bit, every vector slot from 0x100 to 0x17C and the current-vector offset at 0xF00 inside the decoded space, so the top source and the last slot are exercised as well as source 0. A long pseudo-random mix of class, enable-set, enable-clear and vector writes runs against changing request patterns. It drives the priority pick across many pending sets, including the empty set, several fast sources pending together, and writes aimed at read-only, write-only, unaligned and unmapped addresses.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [3:0] {
    RD_ZERO,
    RD_IRQ_STAT,
    RD_FIQ_STAT,
    RD_RAW,
    RD_CLASS,
    RD_ENABLE,
    RD_VECTOR,
    RD_CURRENT
  } rdSel_e;

  typedef struct packed {
    logic   wrClass;
    logic   wrEnSet;
    logic   wrEnClr;
    logic   wrVector;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int NUM_SRC = 32,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobe_t           strb,
  output logic [IDX_W-1:0]  vecIdx
);

  localparam logic [ADDR_W-1:0] OFF_IRQ_STAT = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] OFF_FIQ_STAT = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] OFF_RAW      = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] OFF_CLASS    = ADDR_W'(12'h00C);
  localparam logic [ADDR_W-1:0] OFF_ENABLE   = ADDR_W'(12'h010);
  localparam logic [ADDR_W-1:0] OFF_EN_SET   = ADDR_W'(12'h014);
  localparam logic [ADDR_W-1:0] OFF_EN_CLR   = ADDR_W'(12'h018);
  localparam logic [ADDR_W-1:0] OFF_CURRENT  = ADDR_W'(12'hF00);
  localparam logic [ADDR_W-1:0] VEC_LO       = ADDR_W'(12'h100);
  localparam logic [ADDR_W-1:0] VEC_HI       = ADDR_W'(12'h100 + 4 * NUM_SRC);

  logic [ADDR_W-1:0] vecOff;
  logic              inVec;

  assign vecOff = busAddr - VEC_LO;
  assign inVec  = (busAddr[1:0] == 2'b00) && (busAddr >= VEC_LO) && (busAddr < VEC_HI);
  assign vecIdx = vecOff[IDX_W+1:2];

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_ZERO;
    if (inVec) begin
      strb.rdSel    = RD_VECTOR;
      strb.wrVector = busWe;
    end else begin
      case (busAddr)
        OFF_IRQ_STAT: strb.rdSel = RD_IRQ_STAT;
        OFF_FIQ_STAT: strb.rdSel = RD_FIQ_STAT;
        OFF_RAW:      strb.rdSel = RD_RAW;
        OFF_CLASS: begin
          strb.rdSel   = RD_CLASS;
          strb.wrClass = busWe;
        end
        OFF_ENABLE:   strb.rdSel = RD_ENABLE;
        OFF_EN_SET:   strb.wrEnSet = busWe;
        OFF_EN_CLR:   strb.wrEnClr = busWe;
        OFF_CURRENT:  strb.rdSel = RD_CURRENT;
        default:      strb.rdSel = RD_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int VEC_W   = 32,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [IDX_W-1:0]   vecIdx,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] srcReq,
  output logic [DATA_W-1:0]  rdata,
  output logic               irqOut,
  output logic               fiqOut
);

  logic [NUM_SRC-1:0] rawReg;
  logic [NUM_SRC-1:0] enReg;
  logic [NUM_SRC-1:0] classReg;
  logic [NUM_SRC-1:0] irqPend;
  logic [NUM_SRC-1:0] fiqPend;
  logic [NUM_SRC-1:0] wbits;
  logic [VEC_W-1:0]   vecMem [NUM_SRC];
  logic [IDX_W-1:0]   pickIdx;
  logic               pickHit;
  logic [VEC_W-1:0]   curVec;

  assign wbits = wdata[NUM_SRC-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawReg   <= '0;
      enReg    <= '0;
      classReg <= '0;
    end else begin
      rawReg <= srcReq;
      if (strb.wrClass) classReg <= wbits;
      if (strb.wrEnSet)      enReg <= enReg | wbits;
      else if (strb.wrEnClr) enReg <= enReg & ~wbits;
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)                                      vecMem[g] <= '0;
      else if (strb.wrVector && vecIdx == IDX_W'(g)) vecMem[g] <= wdata[VEC_W-1:0];
    end
  end

  assign irqPend = rawReg & enReg & ~classReg;
  assign fiqPend = rawReg & enReg & classReg;
  assign irqOut  = |irqPend;
  assign fiqOut  = |fiqPend;

  always_comb begin
    pickHit = 1'b0;
    pickIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (irqPend[i]) begin
        pickHit = 1'b1;
        pickIdx = IDX_W'(i);
      end
    end
  end

  assign curVec = pickHit ? vecMem[pickIdx] : '0;

  always_comb begin
    case (strb.rdSel)
      RD_IRQ_STAT: rdata = DATA_W'(irqPend);
      RD_FIQ_STAT: rdata = DATA_W'(fiqPend);
      RD_RAW:      rdata = DATA_W'(rawReg);
      RD_CLASS:    rdata = DATA_W'(classReg);
      RD_ENABLE:   rdata = DATA_W'(enReg);
      RD_VECTOR:   rdata = DATA_W'(vecMem[vecIdx]);
      RD_CURRENT:  rdata = DATA_W'(curVec);
      default:     rdata = '0;
    endcase
  end

endmodule

// File: rtl/intc_vec_regs.sv
module intc_vec_regs
  import intc_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int VEC_W   = 32,
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] srcReq,
  output logic               irqOut,
  output logic               fiqOut
);

  localparam int IDX_W = $clog2(NUM_SRC);

  strobe_t          strb;
  logic [IDX_W-1:0] vecIdx;

  intc_ctrl #(
    .ADDR_W (ADDR_W),
    .NUM_SRC(NUM_SRC),
    .IDX_W  (IDX_W)
  ) uCtrl (
    .busAddr(busAddr),
    .busWe  (busWe),
    .strb   (strb),
    .vecIdx (vecIdx)
  );

  intc_datapath #(
    .NUM_SRC(NUM_SRC),
    .DATA_W (DATA_W),
    .VEC_W  (VEC_W),
    .IDX_W  (IDX_W)
  ) uDp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .vecIdx(vecIdx),
    .wdata (busWdata),
    .srcReq(srcReq),
    .rdata (busRdata),
    .irqOut(irqOut),
    .fiqOut(fiqOut)
  );

endmodule

// File: rtl/intc_vec_regs_chk.sv
module intc_vec_regs_chk #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWe,
  input logic [DATA_W-1:0]  busWdata,
  input logic [DATA_W-1:0]  busRdata,
  input logic [NUM_SRC-1:0] srcReq,
  input logic               irqOut,
  input logic               fiqOut
);

  logic pastValid;

  always_ff @(posedge clk) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  // R8: normal output agrees with the normal status view seen on the bus
  a_r8_irq_vs_status: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(12'h000)) |-> (irqOut == (busRdata != '0)));

  // R8: fast output agrees with the fast status view seen on the bus
  a_r8_fiq_vs_status: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(12'h004)) |-> (fiqOut == (busRdata != '0)));

  // R2: raw view shows the lines from one edge earlier
  a_r2_raw_delay: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && busAddr == ADDR_W'(12'h008)) |-> (busRdata == DATA_W'($past(srcReq))));

  // R10: nothing pending in the normal class gives a zero current vector
  a_r10_cur_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(12'hF00) && !irqOut) |-> (busRdata == '0));

  // R11: unmapped space above the vector slots reads zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr >= ADDR_W'(12'h200) && busAddr != ADDR_W'(12'hF00)) |-> (busRdata == '0));

endmodule

bind intc_vec_regs intc_vec_regs_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .NUM_SRC(NUM_SRC)
) uChk (.*);

// File: tb/sim_intc_vec_regs.sv
`timescale 1ns/1ps
module sim_intc_vec_regs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] srcReq = '0;
  logic        irqOut;
  logic        fiqOut;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  logic [31:0] mRaw, mEn, mSel;
  logic [31:0] mVec [32];

  always #5 clk = ~clk;

  intc_vec_regs u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .srcReq(srcReq),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  function automatic bit isVec(input logic [11:0] a);
    return (a >= 12'h100) && (a < 12'h180) && (a[1:0] == 2'b00);
  endfunction

  function automatic string autoTag(input logic [11:0] a);
    if (isVec(a)) return "R9";
    case (a)
      12'h000: return "R6";
      12'h004: return "R7";
      12'h008: return "R2";
      12'h00C: return "R5";
      12'h010: return "R3";
      12'hF00: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [31:0] expRead(input logic [11:0] a);
    logic [31:0] irqP;
    irqP = mRaw & mEn & ~mSel;
    if (isVec(a)) return mVec[(a - 12'h100) >> 2];
    case (a)
      12'h000: return irqP;
      12'h004: return mRaw & mEn & mSel;
      12'h008: return mRaw;
      12'h00C: return mSel;
      12'h010: return mEn;
      12'hF00: begin
        for (int i = 0; i < 32; i++) if (irqP[i]) return mVec[i];
        return 32'h0;
      end
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mRaw = '0; mEn = '0; mSel = '0;
    for (int i = 0; i < 32; i++) mVec[i] = '0;
  endtask

  // One bus cycle: drive, compare read data, clock, compare outputs
  task automatic cyc(input logic we, input logic [11:0] a, input logic [31:0] d,
                     input logic [31:0] lines, input string tag);
    busWe = we; busAddr = a; busWdata = d; srcReq = lines;
    #1;
    chk((tag == "") ? autoTag(a) : tag, busRdata, expRead(a));
    @(posedge clk);
    if (we) begin
      if (isVec(a)) mVec[(a - 12'h100) >> 2] = d;
      else case (a)
        12'h00C: mSel = d;
        12'h014: mEn = mEn | d;
        12'h018: mEn = mEn & ~d;
        default: ;
      endcase
    end
    mRaw = lines;
    @(negedge clk);
    chk("R8", {31'b0, irqOut}, {31'b0, |(mRaw & mEn & ~mSel)});
    chk("R8", {31'b0, fiqOut}, {31'b0, |(mRaw & mEn & mSel)});
  endtask

  function automatic logic [11:0] pickAddr(input int k);
    case (k % 16)
      0: return 12'h000;   1: return 12'h004;   2: return 12'h008;
      3: return 12'h00C;   4: return 12'h010;   5: return 12'h014;
      6: return 12'h018;   7: return 12'hF00;   8: return 12'h101;
      9: return 12'h01C;  10: return 12'h180;  11: return 12'hF04;
      default: return 12'h100 + 12'(4 * (k % 32));
    endcase
  endfunction

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state over the whole map
    for (int k = 0; k < 16; k++) cyc(1'b0, pickAddr(k), '0, '0, "R1");
    chk("R1", {30'b0, irqOut, fiqOut}, 32'h0);

    // R2: raw lines show through unmasked
    cyc(1'b0, 12'h008, '0, 32'hA5A5_0F0F, "");
    cyc(1'b0, 12'h008, '0, 32'h8000_0001, "R2");
    // R3: set enables, zero bits have no effect
    cyc(1'b1, 12'h014, 32'h0000_00F3, 32'h8000_0001, "");
    cyc(1'b1, 12'h014, 32'h0000_0000, 32'h8000_0001, "");
    cyc(1'b0, 12'h010, '0, 32'h8000_0001, "R3");
    // R4: clear enables, zero bits have no effect
    cyc(1'b1, 12'h018, 32'h0000_0030, 32'h8000_0001, "");
    cyc(1'b1, 12'h018, 32'h0000_0000, 32'h8000_0001, "");
    cyc(1'b0, 12'h010, '0, 32'h8000_0001, "R4");
    // R9: vector slots at both ends
    cyc(1'b1, 12'h100, 32'hDEAD_0000, 32'h8000_0001, "");
    cyc(1'b1, 12'h17C, 32'hBEEF_007C, 32'h8000_0001, "");
    cyc(1'b1, 12'h104, 32'h1111_0004, 32'h8000_0001, "");
    cyc(1'b0, 12'h17C, '0, 32'h8000_0001, "R9");
    // R10: lowest pending normal source wins
    cyc(1'b1, 12'h014, 32'h8000_0003, 32'h8000_0003, "");
    cyc(1'b0, 12'hF00, '0, 32'h8000_0003, "R10");
    // R5/R7: move sources 0 and 1 to the fast class
    cyc(1'b1, 12'h00C, 32'h0000_0003, 32'h8000_0003, "");
    cyc(1'b0, 12'h004, '0, 32'h8000_0003, "R7");
    cyc(1'b0, 12'hF00, '0, 32'h8000_0003, "R10");
    cyc(1'b0, 12'h000, '0, 32'h8000_0003, "R6");
    // R11: writes to read-only addresses change nothing
    cyc(1'b1, 12'h010, 32'hFFFF_FFFF, 32'h0, "");
    cyc(1'b1, 12'h000, 32'hFFFF_FFFF, 32'h0, "");
    cyc(1'b1, 12'hF00, 32'hFFFF_FFFF, 32'h0, "");
    cyc(1'b1, 12'h101, 32'hFFFF_FFFF, 32'h0, "");
    cyc(1'b0, 12'h010, '0, 32'h0, "R11");
    cyc(1'b0, 12'h100, '0, 32'h0, "R11");
    cyc(1'b0, 12'h014, '0, 32'h0, "R11");

    // Mixed traffic under changing request lines
    begin
      logic [31:0] lines;
      lines = 32'h0;
      for (int n = 0; n < 3000; n++) begin
        int op;
        logic [31:0] d;
        op = int'($urandom_range(0, 7));
        d  = $urandom;
        if ($urandom_range(0, 3) == 0) lines = $urandom & $urandom;
        case (op)
          0: cyc(1'b1, 12'h00C, d, lines, "");
          1: cyc(1'b1, 12'h014, d & $urandom, lines, "");
          2: cyc(1'b1, 12'h018, d & $urandom, lines, "");
          3: cyc(1'b1, 12'h100 + 12'(4 * $urandom_range(0, 31)), d, lines, "");
          4: cyc(1'b1, pickAddr(int'($urandom_range(0, 11))), d, lines, "");
          default: cyc(1'b0, pickAddr(int'($urandom_range(0, 63))), '0, lines, "");
        endcase
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule